// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM interface and owns the command pins from reset until the memory is ready for use. After reset it keeps the clock-enable pin low, so the memory's data and strobe pins stay in high impedance. It then waits for a clock-stable qualifier to hold for a set number of cycles, raises clock enable, and walks through a fixed list of commands. The list is: precharge all banks, enable the DLL in the extended mode register, load the base mode register with the DLL reset bit set, precharge all banks again, run two auto refreshes, and load the base mode register again with the DLL reset bit cleared.

All waits are parameters given in clock cycles. These are the startup wait, the precharge recovery, the mode-register recovery, the refresh cycle time and the DLL lock guard. A NOP is driven on every cycle that carries no command. The ready flag rises only when the last command's recovery time has elapsed and the DLL lock guard has also expired. The normal command path then takes over the pins.

Top module: `ddr_pwrup_seq`

## Requirements
- R1: While the synchronous active-high reset is high, and on the first cycle after it is released, cke is 0, init_done is 0, the command pins show NOP, and ba and addr are all zero.
- R2: cke stays 0 until clk_ok has been sampled high on T_STARTUP consecutive rising edges. A low sample restarts the count. cke rises in the cycle that follows the T_STARTUP-th such edge, and no command other than NOP appears while cke is 0.
- R3: Commands are encoded on {cs_n,ras_n,cas_n,we_n} as follows: NOP = 0111, PRECHARGE = 0010, AUTO REFRESH = 0001, LOAD MODE REGISTER = 0000. Each command lasts one cycle, and every cycle without a command shows NOP.
- R4: The first command is a precharge of all banks (addr bit 10 = 1, every other addr bit 0, ba = 0). It is issued in the cycle after cke rises.
- R5: T_RP cycles after the first precharge, a mode register load with ba = 01 and addr = 0 enables the DLL in the extended mode register.
- R6: T_MRD cycles later, a mode register load with ba = 00 writes the base mode register. Its addr carries the burst length code in bits 2:0, the burst type in bit 3, the CAS latency code in bits 6:4, and a 1 in the DLL reset bit, bit 8. All other bits are 0.
- R7: T_MRD cycles after that comes a second precharge of all banks. An auto refresh follows T_RP cycles later, and a second auto refresh follows T_RFC cycles after the first.
- R8: T_RFC cycles after the second refresh, a final mode register load with ba = 00 writes the same operating fields as in R6, with bit 8 = 0.
- R9: Exactly seven commands are issued. init_done first rises in the cycle given by the later of two points: T_MRD cycles after the final mode register load, and T_DLL cycles after the DLL reset load.
- R10: Once init_done is high, it stays high, cke stays high and the command pins show NOP until reset.
- R11: A reset at any point, including during the sequence or after init_done, returns the outputs to the R1 state. The full sequence then runs again from the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_ok | input | 1 | High while the memory clock is stable, synchronous to clk |
| cke | output | 1 | Memory clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address; selects the mode register during loads |
| addr | output | ADDR_W | Row/mode address bus |
| init_done | output | 1 | High once the memory may accept normal commands |

## Verification
The assertions make four assumptions about the inputs:
- clk_ok is already synchronous to clk.
- Every recovery parameter (T_RP, T_MRD, T_RFC) and T_DLL is at least 2.
- T_STARTUP is at least 1.
- Reset is held for at least one edge.

The bench keeps to these limits. It drives clk_ok and rst only on falling edges and uses small cycle counts. It runs two instances in parallel: one whose DLL guard outlasts the command list and one whose guard ends first, so both branches of the ready condition are reached. The stimulus also includes a clk_ok pulse shorter than the startup wait and a reset issued in the middle of the sequence.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_LMR = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111
    } cmd_t;

    typedef enum logic [2:0] {
        AK_ZERO,
        AK_PALL,
        AK_EMR,
        AK_MR_RST,
        AK_MR_RUN
    } akind_t;

    typedef enum logic [1:0] {
        GAP_RP,
        GAP_MRD,
        GAP_RFC
    } gap_t;

    typedef struct packed {
        cmd_t   cmd;
        akind_t ak;
        gap_t   gap;
    } step_t;

    typedef enum logic [2:0] {
        ST_HOLD,
        ST_WAKE,
        ST_ISSUE,
        ST_GAP,
        ST_LOCK,
        ST_DONE
    } state_t;

    localparam int unsigned NUM_STEPS     = 7;
    localparam int unsigned DLL_STEP      = 2;
    localparam int unsigned MR_BL_LSB     = 0;
    localparam int unsigned MR_BT_BIT     = 3;
    localparam int unsigned MR_CL_LSB     = 4;
    localparam int unsigned MR_DLLRST_BIT = 8;
    localparam int unsigned PALL_BIT      = 10;

    // Ordered command list; gap is the spacing to the following command
    function automatic step_t step_lookup(input logic [3:0] idx);
        step_t s;
        case (idx)
            4'd0:    s = '{CMD_PRE, AK_PALL,   GAP_RP};
            4'd1:    s = '{CMD_LMR, AK_EMR,    GAP_MRD};
            4'd2:    s = '{CMD_LMR, AK_MR_RST, GAP_MRD};
            4'd3:    s = '{CMD_PRE, AK_PALL,   GAP_RP};
            4'd4:    s = '{CMD_REF, AK_ZERO,   GAP_RFC};
            4'd5:    s = '{CMD_REF, AK_ZERO,   GAP_RFC};
            4'd6:    s = '{CMD_LMR, AK_MR_RUN, GAP_MRD};
            default: s = '{CMD_NOP, AK_ZERO,   GAP_MRD};
        endcase
        return s;
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/ddr_init_cnt.sv
module ddr_init_cnt #(
    parameter int unsigned W       = 8,
    parameter int unsigned RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         en,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= W'(RST_VAL);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (en && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

    // R2
    no_count_up_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> (cnt_q <= $past(cnt_q)))
        else $error("countdown rose without a load");

endmodule

// File: rtl/ddr_mode_word.sv
module ddr_mode_word
    import ddr_init_pkg::*;
#(
    parameter int unsigned ADDR_W     = 13,
    parameter int unsigned BA_W       = 2,
    parameter logic [2:0]  BURST_LEN  = 3'b010,
    parameter logic        BURST_TYPE = 1'b0,
    parameter logic [2:0]  CAS_LAT    = 3'b010
) (
    input  akind_t              kind,
    output logic [ADDR_W-1:0]   addr,
    output logic [BA_W-1:0]     ba
);

    localparam logic [ADDR_W-1:0] OP_WORD =
        (ADDR_W'(BURST_LEN)  << MR_BL_LSB) |
        (ADDR_W'(BURST_TYPE) << MR_BT_BIT) |
        (ADDR_W'(CAS_LAT)    << MR_CL_LSB);
    localparam logic [ADDR_W-1:0] DLL_RST = ADDR_W'(1) << MR_DLLRST_BIT;
    localparam logic [ADDR_W-1:0] PALL    = ADDR_W'(1) << PALL_BIT;

    always_comb begin
        addr = '0;
        ba   = '0;
        case (kind)
            AK_PALL:   addr = PALL;
            AK_EMR:    ba   = BA_W'(1);
            AK_MR_RST: addr = OP_WORD | DLL_RST;
            AK_MR_RUN: addr = OP_WORD;
            default:   ;
        endcase
    end

endmodule

// File: rtl/ddr_pwrup_seq.sv
module ddr_pwrup_seq
    import ddr_init_pkg::*;
#(
    parameter int unsigned ADDR_W     = 13,
    parameter int unsigned BA_W       = 2,
    parameter int unsigned T_STARTUP  = 20000,
    parameter int unsigned T_RP       = 3,
    parameter int unsigned T_MRD      = 2,
    parameter int unsigned T_RFC      = 8,
    parameter int unsigned T_DLL      = 200,
    parameter logic [2:0]  BURST_LEN  = 3'b010,
    parameter logic        BURST_TYPE = 1'b0,
    parameter logic [2:0]  CAS_LAT    = 3'b010
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_ok,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              init_done
);

    localparam int unsigned GAP_MAX = max3(T_RP, T_MRD, T_RFC);
    localparam int unsigned GW      = $clog2(GAP_MAX + 1);
    localparam int unsigned SW      = $clog2(T_STARTUP + 1);
    localparam int unsigned DW      = $clog2(T_DLL + 1);
    localparam int unsigned STEP_W  = $clog2(NUM_STEPS);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);
    localparam logic [STEP_W-1:0] DLL_IDX   = STEP_W'(DLL_STEP);

    state_t              state_q, state_d;
    logic [STEP_W-1:0]   step_q;
    logic                armed_q;
    step_t               cur;
    logic [GW-1:0]       gap_val;
    logic                start_zero, gap_zero, guard_zero;
    logic                guard_load, dll_ok;
    cmd_t                cmd_o;
    akind_t              ak_o;

    assign cur = step_lookup(4'(step_q));

    always_comb begin
        case (cur.gap)
            GAP_RP:  gap_val = GW'(T_RP - 2);
            GAP_RFC: gap_val = GW'(T_RFC - 2);
            default: gap_val = GW'(T_MRD - 2);
        endcase
    end

    // Startup wait: reloads whenever the clock is not yet stable
    ddr_init_cnt #(.W(SW), .RST_VAL(T_STARTUP - 1)) u_start_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     ((state_q == ST_HOLD) && !clk_ok),
        .en       (state_q == ST_HOLD),
        .load_val (SW'(T_STARTUP - 1)),
        .zero     (start_zero)
    );

    // Spacing between consecutive commands
    ddr_init_cnt #(.W(GW), .RST_VAL(0)) u_gap_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (state_q == ST_ISSUE),
        .en       (state_q == ST_GAP),
        .load_val (gap_val),
        .zero     (gap_zero)
    );

    // DLL lock guard, started by the DLL reset load
    assign guard_load = (state_q == ST_ISSUE) && (step_q == DLL_IDX);

    ddr_init_cnt #(.W(DW), .RST_VAL(0)) u_guard_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (guard_load),
        .en       (1'b1),
        .load_val (DW'(T_DLL - 2)),
        .zero     (guard_zero)
    );

    assign dll_ok = armed_q && guard_zero;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_HOLD:  if (clk_ok && start_zero) state_d = ST_WAKE;
            ST_WAKE:  state_d = ST_ISSUE;
            ST_ISSUE: state_d = ST_GAP;
            ST_GAP: begin
                if (gap_zero) begin
                    if (step_q != LAST_STEP) state_d = ST_ISSUE;
                    else if (dll_ok)        state_d = ST_DONE;
                    else                    state_d = ST_LOCK;
                end
            end
            ST_LOCK:  if (dll_ok) state_d = ST_DONE;
            default:  state_d = ST_DONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HOLD;
            step_q  <= '0;
            armed_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if ((state_q == ST_GAP) && gap_zero && (step_q != LAST_STEP)) begin
                step_q <= step_q + 1'b1;
            end
            if (guard_load) begin
                armed_q <= 1'b1;
            end
        end
    end

    assign cmd_o = (state_q == ST_ISSUE) ? cur.cmd : CMD_NOP;
    assign ak_o  = (state_q == ST_ISSUE) ? cur.ak  : AK_ZERO;

    ddr_mode_word #(
        .ADDR_W     (ADDR_W),
        .BA_W       (BA_W),
        .BURST_LEN  (BURST_LEN),
        .BURST_TYPE (BURST_TYPE),
        .CAS_LAT    (CAS_LAT)
    ) u_mode_word (
        .kind (ak_o),
        .addr (addr),
        .ba   (ba)
    );

    assign {cs_n, ras_n, cas_n, we_n} = cmd_o;
    assign cke       = (state_q != ST_HOLD);
    assign init_done = (state_q == ST_DONE);

    // R2
    cke_low_nop_chk: assert property (@(posedge clk) disable iff (rst)
        !cke |-> (cmd_o == CMD_NOP))
        else $error("command issued with clock enable low");

    // R2
    wake_needs_clk_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cke) |-> $past(clk_ok))
        else $error("clock enable raised without a stable clock");

    // R3
    single_cycle_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_o != CMD_NOP) |=> (cmd_o == CMD_NOP))
        else $error("two commands back to back");

    // R9
    done_after_lock_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(init_done) |-> $past(dll_ok))
        else $error("ready before DLL guard expired");

    // R10
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        init_done |=> (init_done && cke))
        else $error("ready flag dropped");

endmodule

// File: tb/ddr_pwrup_seq_tb.sv
module ddr_pwrup_seq_tb;

    localparam int TS     = 12;
    localparam int TRP    = 3;
    localparam int TMRD   = 2;
    localparam int TRFC   = 5;
    localparam int TDLL_A = 40;
    localparam int TDLL_B = 6;
    localparam logic [2:0] BL = 3'b011;
    localparam logic       BT = 1'b1;
    localparam logic [2:0] CL = 3'b011;
    localparam int MRW = (int'(CL) << 4) | (int'(BT) << 3) | int'(BL);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clk_ok = 1'b0;
    int   cyc = 0;
    int   errors = 0;
    int   nchk = 0;

    logic        cke_w [2];
    logic        cs_w [2];
    logic        ras_w [2];
    logic        cas_w [2];
    logic        we_w [2];
    logic [1:0]  ba_w [2];
    logic [12:0] addr_w [2];
    logic        done_w [2];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ddr_pwrup_seq #(.T_STARTUP(TS), .T_RP(TRP), .T_MRD(TMRD), .T_RFC(TRFC),
        .T_DLL(TDLL_A), .BURST_LEN(BL), .BURST_TYPE(BT), .CAS_LAT(CL)) u_dut (
        .clk(clk), .rst(rst), .clk_ok(clk_ok), .cke(cke_w[0]), .cs_n(cs_w[0]),
        .ras_n(ras_w[0]), .cas_n(cas_w[0]), .we_n(we_w[0]), .ba(ba_w[0]),
        .addr(addr_w[0]), .init_done(done_w[0]));

    ddr_pwrup_seq #(.T_STARTUP(TS), .T_RP(TRP), .T_MRD(TMRD), .T_RFC(TRFC),
        .T_DLL(TDLL_B), .BURST_LEN(BL), .BURST_TYPE(BT), .CAS_LAT(CL)) u_dut_s (
        .clk(clk), .rst(rst), .clk_ok(clk_ok), .cke(cke_w[1]), .cs_n(cs_w[1]),
        .ras_n(ras_w[1]), .cas_n(cas_w[1]), .we_n(we_w[1]), .ba(ba_w[1]),
        .addr(addr_w[1]), .init_done(done_w[1]));

    // Event log, filled on falling edges
    bit          logging = 1'b0;
    int          nev [2];
    int          viol [2];
    int          first_cke [2];
    int          first_done [2];
    int          post_bad [2];
    int          ev_cyc [2][8];
    logic [3:0]  ev_cmd [2][8];
    logic [1:0]  ev_ba [2][8];
    logic [12:0] ev_addr [2][8];

    function automatic logic [3:0] cmd_of(input int d);
        return {cs_w[d], ras_w[d], cas_w[d], we_w[d]};
    endfunction

    always @(negedge clk) begin
        if (logging) begin
            for (int d = 0; d < 2; d++) begin
                if (cmd_of(d) != 4'b0111) begin
                    if (!cke_w[d]) viol[d]++;
                    else begin
                        if (nev[d] < 8) begin
                            ev_cyc[d][nev[d]]  = cyc;
                            ev_cmd[d][nev[d]]  = cmd_of(d);
                            ev_ba[d][nev[d]]   = ba_w[d];
                            ev_addr[d][nev[d]] = addr_w[d];
                        end
                        nev[d]++;
                    end
                end
                if (cke_w[d] && first_cke[d] < 0) first_cke[d] = cyc;
                if (done_w[d] && first_done[d] < 0) first_done[d] = cyc;
                if (first_done[d] >= 0 && (!done_w[d] || !cke_w[d] || cmd_of(d) != 4'b0111))
                    post_bad[d]++;
            end
        end
    end

    task automatic clear_log();
        for (int d = 0; d < 2; d++) begin
            nev[d] = 0; viol[d] = 0; first_cke[d] = -1;
            first_done[d] = -1; post_bad[d] = 0;
        end
        logging = 1'b1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_gap(input int i);
        case (i)
            0: return 1;
            1: return TRP;
            2: return TMRD;
            3: return TMRD;
            4: return TRP;
            5: return TRFC;
            default: return TRFC;
        endcase
    endfunction

    function automatic int exp_cmd(input int i);
        case (i)
            0, 3: return 4'b0010;
            4, 5: return 4'b0001;
            default: return 4'b0000;
        endcase
    endfunction

    function automatic int exp_addr(input int i);
        case (i)
            0, 3: return 13'h400;
            2: return MRW | 13'h100;
            6: return MRW;
            default: return 0;
        endcase
    endfunction

    function automatic string step_tag(input int i);
        case (i)
            0: return "R4";
            1: return "R5";
            2: return "R6";
            3, 4, 5: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic check_reset(input string tag);
        for (int d = 0; d < 2; d++) begin
            chk({tag, " cke"}, int'(cke_w[d]), 0);
            chk({tag, " init_done"}, int'(done_w[d]), 0);
            chk({tag, " R3 command NOP"}, int'(cmd_of(d)), 4'b0111);
            chk({tag, " ba"}, int'(ba_w[d]), 0);
            chk({tag, " addr"}, int'(addr_w[d]), 0);
        end
    endtask

    task automatic check_run(input int w);
        for (int d = 0; d < 2; d++) begin
            int t;
            int dll_c;
            int done_exp;
            int tdll;
            tdll = (d == 0) ? TDLL_A : TDLL_B;
            chk($sformatf("R2 dut%0d cke rise cycle", d), first_cke[d], w);
            chk($sformatf("R2 dut%0d commands while cke low", d), viol[d], 0);
            chk($sformatf("R9 dut%0d command count", d), nev[d], 7);
            t = w;
            for (int i = 0; i < 7; i++) begin
                t += exp_gap(i);
                chk($sformatf("%s dut%0d step%0d cycle", step_tag(i), d, i), ev_cyc[d][i], t);
                chk($sformatf("%s R3 dut%0d step%0d cmd", step_tag(i), d, i),
                    int'(ev_cmd[d][i]), exp_cmd(i));
                chk($sformatf("%s dut%0d step%0d ba", step_tag(i), d, i),
                    int'(ev_ba[d][i]), (i == 1) ? 1 : 0);
                chk($sformatf("%s dut%0d step%0d addr", step_tag(i), d, i),
                    int'(ev_addr[d][i]), exp_addr(i));
            end
            dll_c = w + 1 + TRP + TMRD;
            done_exp = (t + TMRD > dll_c + tdll) ? t + TMRD : dll_c + tdll;
            chk($sformatf("R9 dut%0d init_done cycle", d), first_done[d], done_exp);
            chk($sformatf("R10 dut%0d post-ready hold", d), post_bad[d], 0);
        end
    endtask

    initial begin
        #50us;
        errors++;
        nchk++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, nchk);
        $finish;
    end

    initial begin
        int k;
        int r;
        repeat (3) @(negedge clk);
        check_reset("R1 in reset");
        rst = 1'b0;
        clear_log();
        @(negedge clk);
        check_reset("R1 after release");
        repeat (3) @(negedge clk);
        // R2: a stable pulse shorter than the wait must not wake the memory
        clk_ok = 1'b1;
        repeat (5) @(negedge clk);
        clk_ok = 1'b0;
        repeat (3) @(negedge clk);
        clk_ok = 1'b1;
        k = cyc;
        wait_until(k + TS + TDLL_A + 40);
        check_run(k + TS);

        // R11: reset after ready
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check_reset("R11 after ready");
        rst = 1'b0;
        r = cyc;
        wait_until(r + TS + 8);
        // R11: reset in the middle of the sequence
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check_reset("R11 mid sequence");
        clear_log();
        rst = 1'b0;
        r = cyc;
        wait_until(r + TS + TDLL_A + 40);
        check_run(r + TS);

        $display("Result: errors=%0d of %0d checks", errors, nchk);
        $finish;
    end

endmodule